// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out buffer built as a chain of single-word stages, by default 64 words of 4 bits. It uses no read or write pointers. Each stage holds one word and a valid bit. On a clock edge a stage takes the word from the stage before it when it is empty and its predecessor holds data. A written word therefore falls through to the output stage, one stage per cycle. When a word is read, the empty slot it leaves travels back toward the input at the same rate.

The write side has a shift-in strobe, a data input and an input-ready flag. The read side has a shift-out strobe, a data output and an output-ready flag. The data output goes to high impedance when the output enable is low.

Deeper buffers are built by chaining instances:
- The upstream output-ready drives the downstream shift-in.
- The downstream input-ready drives the upstream shift-out.
- The upstream data output feeds the downstream data input.

Each cycle in which both flags are high moves exactly one word between the two instances.

Top module: `ripple_fifo`

## Requirements
- R1: While `rst_n` is low, every stage is empty, `in_ready_o` is 1 and `out_ready_o` is 0, and this state holds after reset is released.
- R2: Into an empty buffer, a word accepted at a clock edge raises `out_ready_o` exactly DEPTH-1 edges later, with that word on `data_o`.
- R3: Words leave in the order they were accepted. A stage holding a word that is not released keeps it unchanged. After DEPTH accepted words and no reads, once the contents settle, `in_ready_o` is 0.
- R4: With `shift_out_i` held high, each word that reaches the output produces `out_ready_o` as a one-cycle pulse and is removed at the edge that ends the pulse.
- R5: A shift-in while `in_ready_o` is 0 is ignored: no word is added and the contents read out later are unchanged.
- R6: A shift-out while `out_ready_o` is 0 is ignored: `out_ready_o` stays 0 and `data_o` keeps its last value.
- R7: In a full buffer, a word removed at a clock edge raises `in_ready_o` exactly DEPTH-1 edges later, once the freed slot reaches the input stage.
- R8: With `shift_in_i` held high, each rise of `in_ready_o` accepts one word and `in_ready_o` is low again in the next cycle.
- R9: Two chained instances hold 2*DEPTH words, refuse a further write, and deliver all words in order.
- R10: With `out_en_i` at 0, `data_o` is high impedance on every bit. With `out_en_i` at 1, it carries the output stage's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset, released synchronously |
| shift_in_i | input | 1 | Write strobe, acted on when `in_ready_o` is high |
| data_i | input | WIDTH | Word to write |
| in_ready_o | output | 1 | Input stage is empty |
| shift_out_i | input | 1 | Read strobe, acted on when `out_ready_o` is high |
| data_o | output | WIDTH | Output stage word, three-state |
| out_ready_o | output | 1 | Output stage holds a word |
| out_en_i | input | 1 | Output enable for `data_o` |

## Verification
The bench measures the fall-through and bubble-back latencies edge by edge. A stage that skipped a step or stalled for a cycle would shift either count away from DEPTH-1. It holds each strobe high to check that the ready flags become single-cycle pulses. A design whose output stage could refill in the same cycle it is read would show a level instead of a pulse, or would duplicate a word. It writes into a full buffer and reads from an empty one, then drains the buffer and compares the words. An accepted extra word would show up as a surplus word, and a read-side glitch would show up as a changed output. A chained pair is filled to 128 words, offered a 129th, and emptied. Any loss, duplication or reordering at the hand-off shows up in the sequence that comes out.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned RF_DEPTH_DEF = 64;
  localparam int unsigned RF_WIDTH_DEF = 4;
endpackage

// File: rtl/ripple_stage.sv
module ripple_stage #(
  parameter int unsigned WIDTH = ripple_fifo_pkg::RF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_vld_i,
  input  logic [WIDTH-1:0] up_dat_i,
  input  logic             rel_i,
  output logic             take_o,
  output logic             vld_o,
  output logic [WIDTH-1:0] dat_o
);
  logic             vld_q, vld_d;
  logic [WIDTH-1:0] dat_q;
  logic             take;

  always_comb begin
    take  = ~vld_q & up_vld_i;
    vld_d = take | (vld_q & ~rel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) dat_q <= up_dat_i;
    end
  end

  assign take_o = take;
  assign vld_o  = vld_q;
  assign dat_o  = dat_q;

  // R3: a held word that is not released stays put
  a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rel_i) |=> (vld_q && $stable(dat_q)));
endmodule

// File: rtl/ripple_out_port.sv
module ripple_out_port #(
  parameter int unsigned WIDTH = ripple_fifo_pkg::RF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             so_i,
  input  logic             oe_i,
  input  logic             vld_i,
  input  logic             fill_i,
  input  logic [WIDTH-1:0] dat_i,
  output logic             pop_o,
  output logic             rdy_o,
  output logic [WIDTH-1:0] q_o
);
  always_comb begin
    pop_o = so_i & vld_i;
    rdy_o = vld_i;
  end

  assign q_o = oe_i ? dat_i : {WIDTH{1'bz}};

  // R4: a read of the output stage leaves it empty for one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (so_i && vld_i) |=> !vld_i);

  // R6: a read with nothing ready changes nothing
  a_r6_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (so_i && !vld_i && !fill_i) |=> (!vld_i && $stable(dat_i)));
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int unsigned DEPTH = ripple_fifo_pkg::RF_DEPTH_DEF,
  parameter int unsigned WIDTH = ripple_fifo_pkg::RF_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             in_ready_o,
  input  logic             shift_out_i,
  output logic [WIDTH-1:0] data_o,
  output logic             out_ready_o,
  input  logic             out_en_i
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] take;
  logic [WIDTH-1:0] dat [DEPTH];
  logic             pop;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic             up_v;
    logic [WIDTH-1:0] up_d;
    logic             rel;

    if (k == 0) begin : g_head
      assign up_v = shift_in_i;
      assign up_d = data_i;
    end else begin : g_body
      assign up_v = vld[k-1];
      assign up_d = dat[k-1];
    end

    if (k == LAST) begin : g_tail
      assign rel = pop;
    end else begin : g_mid
      assign rel = take[k+1];
    end

    ripple_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_vld_i (up_v),
      .up_dat_i (up_d),
      .rel_i    (rel),
      .take_o   (take[k]),
      .vld_o    (vld[k]),
      .dat_o    (dat[k])
    );
  end

  assign in_ready_o = ~vld[0];

  ripple_out_port #(.WIDTH(WIDTH)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .so_i   (shift_out_i),
    .oe_i   (out_en_i),
    .vld_i  (vld[LAST]),
    .fill_i (take[LAST]),
    .dat_i  (dat[LAST]),
    .pop_o  (pop),
    .rdy_o  (out_ready_o),
    .q_o    (data_o)
  );

  // R5: a refused write leaves the input stage occupied
  a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_in_i && !in_ready_o && !take[1]) |=> !in_ready_o);

  // R8: an accepted word drops input-ready for the next cycle
  a_r8_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take[0] |=> !in_ready_o);
endmodule

// File: tb/ripple_fifo_tb_top.sv
module ripple_fifo_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 64;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // standalone instance
  logic             s_si = 1'b0, s_so = 1'b0, s_oe = 1'b1;
  logic [WIDTH-1:0] s_din = '0;
  logic             s_ir, s_or;
  wire  [WIDTH-1:0] s_dout;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_in_i(s_si), .data_i(s_din), .in_ready_o(s_ir),
    .shift_out_i(s_so), .data_o(s_dout), .out_ready_o(s_or), .out_en_i(s_oe));

  // chained pair
  logic             c_si = 1'b0, c_so = 1'b0;
  logic [WIDTH-1:0] c_din = '0;
  logic             c_ir, c_or, ab_rdy, ba_rdy;
  wire  [WIDTH-1:0] ab_dat, c_dout;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) casc_a_i (
    .clk(clk), .rst_n(rst_n), .shift_in_i(c_si), .data_i(c_din), .in_ready_o(c_ir),
    .shift_out_i(ba_rdy), .data_o(ab_dat), .out_ready_o(ab_rdy), .out_en_i(1'b1));

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) casc_b_i (
    .clk(clk), .rst_n(rst_n), .shift_in_i(ab_rdy), .data_i(ab_dat), .in_ready_o(ba_rdy),
    .shift_out_i(c_so), .data_o(c_dout), .out_ready_o(c_or), .out_en_i(1'b1));

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [WIDTH-1:0] sw(input int i);
    return WIDTH'((i * 5 + 3) % 16);
  endfunction

  function automatic logic [WIDTH-1:0] cw(input int i);
    return WIDTH'((i * 7 + i / 16) % 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n, acc, got, g, hi;
    // R1: reset state
    repeat (3) tick();
    chk(s_ir == 1'b1, "R1", s_ir, 1);
    chk(s_or == 1'b0, "R1", s_or, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(s_ir == 1'b1, "R1", s_ir, 1);
    chk(s_or == 1'b0, "R1", s_or, 0);
    chk(c_ir == 1'b1 && c_or == 1'b0, "R1", {c_ir, c_or}, 2);

    // R2: fall-through latency
    s_din = 4'h5; s_si = 1'b1; tick(); s_si = 1'b0;
    n = 0;
    while (!s_or && n < 200) begin tick(); n++; end
    chk(n == DEPTH - 1, "R2", n, DEPTH - 1);
    chk(s_dout == 4'h5, "R2", s_dout, 5);

    // R6: read with nothing ready
    s_so = 1'b1; tick(); s_so = 1'b0;
    chk(s_or == 1'b0, "R6", s_or, 0);
    s_so = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(s_or == 1'b0, "R6", s_or, 0);
      chk(s_dout == 4'h5, "R6", s_dout, 5);
    end
    s_so = 1'b0;

    // R10: output enable
    s_oe = 1'b0; #0.5;
    chk(s_dout === {WIDTH{1'bz}}, "R10", 0, 1);
    s_oe = 1'b1; #0.5;
    chk(s_dout === 4'h5, "R10", s_dout, 5);

    // R3: fill to capacity
    acc = 0; g = 0; s_si = 1'b1; s_din = sw(0);
    while (acc < DEPTH && g < 1000) begin
      if (s_ir) begin tick(); acc++; s_din = sw(acc); end
      else tick();
      g++;
    end
    s_si = 1'b0;
    chk(acc == DEPTH, "R3", acc, DEPTH);
    repeat (DEPTH + 5) tick();
    chk(s_ir == 1'b0, "R3", s_ir, 0);
    chk(s_or == 1'b1, "R3", s_or, 1);

    // R5: writes into a full buffer
    s_din = 4'hA; s_si = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(s_ir == 1'b0, "R5", s_ir, 0);
    end
    s_si = 1'b0;

    // R7: bubble-back latency
    chk(s_dout == sw(0), "R3", s_dout, sw(0));
    s_so = 1'b1; tick(); s_so = 1'b0;
    n = 0;
    while (!s_ir && n < 200) begin tick(); n++; end
    chk(n == DEPTH - 1, "R7", n, DEPTH - 1);

    // R8: input-ready pulse with shift-in held
    s_din = sw(DEPTH); s_si = 1'b1;
    chk(s_ir == 1'b1, "R8", s_ir, 1);
    tick();
    chk(s_ir == 1'b0, "R8", s_ir, 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(s_ir == 1'b0, "R8", s_ir, 0);
    end
    s_si = 1'b0;

    // R3/R5: drain and compare, the refused word must be absent
    s_so = 1'b1; got = 0;
    for (int i = 0; i < 400; i++) begin
      if (s_or) begin
        chk(s_dout == sw(got + 1), "R3", s_dout, sw(got + 1));
        got++;
      end
      tick();
    end
    chk(got == DEPTH, "R5", got, DEPTH);

    // R4: output-ready pulse with shift-out held
    s_din = 4'h9; s_si = 1'b1; tick(); s_si = 1'b0;
    hi = 0;
    for (int i = 0; i < DEPTH + 10; i++) begin
      if (s_or) begin
        hi++;
        chk(s_dout == 4'h9, "R4", s_dout, 9);
      end
      tick();
    end
    chk(hi == 1, "R4", hi, 1);
    s_so = 1'b0;

    // R9: chained pair
    acc = 0; g = 0; c_si = 1'b1; c_din = cw(0);
    while (acc < 2 * DEPTH && g < 3000) begin
      if (c_ir) begin tick(); acc++; c_din = cw(acc); end
      else tick();
      g++;
    end
    c_si = 1'b0;
    chk(acc == 2 * DEPTH, "R9", acc, 2 * DEPTH);
    repeat (3 * DEPTH) tick();
    chk(c_ir == 1'b0, "R9", c_ir, 0);
    c_din = 4'hE; c_si = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(c_ir == 1'b0, "R9", c_ir, 0);
    end
    c_si = 1'b0;
    c_so = 1'b1; got = 0;
    for (int i = 0; i < 1000; i++) begin
      if (c_or) begin
        chk(c_dout == cw(got), "R9", c_dout, cw(got));
        got++;
      end
      tick();
    end
    c_so = 1'b0;
    chk(got == 2 * DEPTH, "R9", got, 2 * DEPTH);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule